// File: doc/BRIEF.md
# Tag-Only Cache Metadata Controller

This block tracks the bookkeeping side of a set-associative cache: per-way valid bits, dirty bits, tags and recency ages. Capacity, block size and associativity are fixed at elaboration as powers of two: 2^C_BITS bytes in total, 2^B_BITS bytes per block, and 2^S_BITS ways per set. No data array exists. Each request carries a 32-bit address and a read/write flag. The controller answers hit or miss and updates the metadata in the same step. The update follows the write policy presented with the request, which is either write-back with allocate or write-through without allocate.

Nine saturating event counters record traffic. Software reads them one at a time through a select input. A synchronous clear input zeroes all of them. Requests use a valid/ready handshake on the way in. The response is a single-cycle pulse with no back-pressure. The controller lowers `req_ready` while that pulse is out, so one access is in flight at most, and a source must hold its request until it sees `req_ready` high.

Top module: `cache_meta_ctrl`

## Requirements
- R1: An address splits into a block offset (bits B_BITS-1:0), a set index (the next C_BITS-B_BITS-S_BITS bits) and a tag (the remaining upper bits). Two addresses that differ only in offset map to the same block, so the second of them hits.
- R2: After reset every way is invalid, so the first access to any block misses. After reset every counter reads 0, `req_ready` is 1 and `rsp_valid` is 0.
- R3: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. `rsp_valid` is 1 for exactly the next cycle, and `rsp_hit` is valid during that cycle. `req_ready` is 0 during that cycle.
- R4: A fill goes to the lowest-numbered invalid way of the set. If no way in the set is invalid, the fill goes to the least-recently-used way.
- R5: Every hit and every fill makes the touched way the most recently used in its set.
- R6: Under write-back (`wp_write_back`=1), a write hit marks the block dirty. A write miss allocates the block and marks it dirty. A read fill installs the block clean.
- R7: Under write-through (`wp_write_back`=0), a write miss allocates nothing and does not count in the write-miss or total-miss counters. A write hit leaves the dirty bit unchanged.
- R8: The byte counter adds 2^B_BITS for each block fill. It adds another 2^B_BITS when the fill evicts a valid dirty block. It adds 4 for every write-through write, whether that write hits or misses.
- R9: `stat_sel` selects a counter: 0 accesses, 1 reads, 2 read hits, 3 read misses, 4 writes, 5 write hits, 6 write misses, 7 total misses (read misses plus write-back write misses), 8 bytes transferred. Any other value reads 0.
- R10: Each counter is CNT_W bits wide. Once a counter reaches its all-ones value it stays there.
- R11: `stats_clear` zeroes every counter on the next edge. If an access is accepted on that same edge, the clear wins and the access is not counted, but the access still updates the metadata.
- R12: The write policy is sampled per access at acceptance, so successive accesses may use different policies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wp_write_back | input | 1 | 1 = write-back with allocate, 0 = write-through without allocate; sampled at acceptance |
| stats_clear | input | 1 | Synchronous clear of all counters |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address |
| rsp_valid | output | 1 | Result pulse, one cycle after acceptance |
| rsp_hit | output | 1 | 1 = hit, valid while rsp_valid is 1 |
| stat_sel | input | 4 | Counter select |
| stat_value | output | CNT_W | Selected counter value |

## Verification
A counter clear and an accepted access can land on the same edge. The bench provokes this by raising `stats_clear` during the acceptance cycle of a read miss. It then expects every counter to read zero. To confirm that the metadata still changed, it repeats the same read and expects a hit, with the access and read-hit counters at one. A second pairing to watch is a fill that evicts a dirty block: one access must then add two block transfers to the byte counter in the same cycle, and the bench checks the running total against this.

// File: rtl/cache_meta_pkg.sv
package cache_meta_pkg;
  localparam int NSTAT = 9;
  localparam int STAT_SEL_W = 4;

  typedef enum logic [STAT_SEL_W-1:0] {
    ST_ACC   = 4'd0,
    ST_RD    = 4'd1,
    ST_RDH   = 4'd2,
    ST_RDM   = 4'd3,
    ST_WR    = 4'd4,
    ST_WRH   = 4'd5,
    ST_WRM   = 4'd6,
    ST_MISS  = 4'd7,
    ST_BYTES = 4'd8
  } stat_id_e;
endpackage

// File: rtl/cmc_tag_store.sv
module cmc_tag_store #(
  parameter int SETS  = 32,
  parameter int WAYS  = 2,
  parameter int SET_W = 5,
  parameter int TAG_W = 23,
  parameter int WAY_W = 1,
  parameter int AGE_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] rd_set,
  input  logic [TAG_W-1:0] rd_tag,
  input  logic             upd_en,
  input  logic [WAY_W-1:0] upd_way,
  input  logic             upd_fill,
  input  logic             upd_dirty_set,
  input  logic             upd_dirty_clr,
  output logic [WAYS-1:0]  hit_vec,
  output logic [WAYS-1:0]  valid_row,
  output logic [WAYS-1:0]  dirty_row,
  output logic [AGE_W-1:0] age_row [WAYS]
);
  logic [WAYS-1:0]  vld_q   [SETS];
  logic [WAYS-1:0]  drt_q   [SETS];
  logic [TAG_W-1:0] tag_q   [SETS][WAYS];
  logic [AGE_W-1:0] age_q   [SETS][WAYS];

  always_comb begin
    valid_row = vld_q[rd_set];
    dirty_row = drt_q[rd_set];
    for (int w = 0; w < WAYS; w++) begin
      hit_vec[w] = vld_q[rd_set][w] && (tag_q[rd_set][w] == rd_tag);
      age_row[w] = age_q[rd_set][w];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        drt_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) age_q[s][w] <= AGE_W'(w);
      end
    end else if (upd_en) begin
      if (upd_fill) vld_q[rd_set][upd_way] <= 1'b1;
      if (upd_dirty_set)      drt_q[rd_set][upd_way] <= 1'b1;
      else if (upd_dirty_clr) drt_q[rd_set][upd_way] <= 1'b0;
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == upd_way)
          age_q[rd_set][w] <= '0;
        else if (age_q[rd_set][w] < age_q[rd_set][upd_way])
          age_q[rd_set][w] <= AGE_W'(age_q[rd_set][w] + 1'b1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (upd_en && upd_fill) tag_q[rd_set][upd_way] <= rd_tag;
  end

  // R1: a tag is never resident twice in one set
  a_r1_unique_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
endmodule

// File: rtl/cmc_victim_sel.sv
module cmc_victim_sel #(
  parameter int WAYS  = 2,
  parameter int WAY_W = 1,
  parameter int AGE_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WAYS-1:0]  valid_row,
  input  logic [AGE_W-1:0] age_row [WAYS],
  output logic [WAY_W-1:0] victim
);
  logic [WAY_W-1:0] lru_way;
  logic [WAY_W-1:0] free_way;

  always_comb begin
    lru_way  = '0;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (age_row[w] == AGE_W'(WAYS - 1)) lru_way = WAY_W'(w);
      if (!valid_row[w])                  free_way = WAY_W'(w);
    end
    victim = (&valid_row) ? lru_way : free_way;
  end

  // R4: a free way is always preferred over eviction
  a_r4_free_first: assert property (@(posedge clk) disable iff (!rst_n)
    !(&valid_row) |-> !valid_row[victim]);
endmodule

// File: rtl/cmc_stats.sv
module cmc_stats import cache_meta_pkg::*; #(
  parameter int CNT_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clear,
  input  logic                  ev_fire,
  input  logic                  ev_write,
  input  logic                  ev_hit,
  input  logic                  ev_wb,
  input  logic [CNT_W-1:0]      ev_bytes,
  input  logic [STAT_SEL_W-1:0] sel,
  output logic [CNT_W-1:0]      value
);
  logic [CNT_W-1:0] cnt_q [NSTAT];
  logic [CNT_W-1:0] inc   [NSTAT];
  logic [CNT_W:0]   sum   [NSTAT];
  logic rd_ev, wr_ev, wb_wmiss;

  always_comb begin
    rd_ev    = ev_fire && !ev_write;
    wr_ev    = ev_fire && ev_write;
    wb_wmiss = wr_ev && !ev_hit && ev_wb;
    inc[ST_ACC]   = CNT_W'(ev_fire);
    inc[ST_RD]    = CNT_W'(rd_ev);
    inc[ST_RDH]   = CNT_W'(rd_ev && ev_hit);
    inc[ST_RDM]   = CNT_W'(rd_ev && !ev_hit);
    inc[ST_WR]    = CNT_W'(wr_ev);
    inc[ST_WRH]   = CNT_W'(wr_ev && ev_hit);
    inc[ST_WRM]   = CNT_W'(wb_wmiss);
    inc[ST_MISS]  = CNT_W'((rd_ev && !ev_hit) || wb_wmiss);
    inc[ST_BYTES] = ev_fire ? ev_bytes : '0;
    for (int i = 0; i < NSTAT; i++) sum[i] = {1'b0, cnt_q[i]} + {1'b0, inc[i]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSTAT; i++) cnt_q[i] <= '0;
    end else begin
      for (int i = 0; i < NSTAT; i++) begin
        if (clear)            cnt_q[i] <= '0;
        else if (sum[i][CNT_W]) cnt_q[i] <= '1;
        else                  cnt_q[i] <= sum[i][CNT_W-1:0];
      end
    end
  end

  always_comb begin
    value = '0;
    for (int i = 0; i < NSTAT; i++)
      if (sel == STAT_SEL_W'(i)) value = cnt_q[i];
  end

  for (genvar g = 0; g < NSTAT; g++) begin : g_sat_chk
    // R10: a saturated counter holds until cleared
    a_r10_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q[g] == '1 && !clear) |=> cnt_q[g] == '1);
  end

  // R7: a write-through write never moves the write-miss count
  a_r7_wt_no_wmiss: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_fire && ev_write && !ev_wb && !clear) |=> $stable(cnt_q[ST_WRM]));

  // R9: read hits plus read misses equal reads while unsaturated
  a_r9_read_split: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q[ST_RD] != '1) |-> (cnt_q[ST_RD] == CNT_W'(cnt_q[ST_RDH] + cnt_q[ST_RDM])));
endmodule

// File: rtl/cache_meta_ctrl.sv
module cache_meta_ctrl import cache_meta_pkg::*; #(
  parameter int C_BITS = 10,
  parameter int B_BITS = 4,
  parameter int S_BITS = 1,
  parameter int CNT_W  = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wp_write_back,
  input  logic                  stats_clear,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [31:0]           req_addr,
  output logic                  rsp_valid,
  output logic                  rsp_hit,
  input  logic [STAT_SEL_W-1:0] stat_sel,
  output logic [CNT_W-1:0]      stat_value
);
  localparam int WAYS  = 1 << S_BITS;
  localparam int IDX_W = C_BITS - B_BITS - S_BITS;
  localparam int SETS  = 1 << IDX_W;
  localparam int SET_W = (IDX_W > 0) ? IDX_W : 1;
  localparam int TAG_W = 32 - B_BITS - IDX_W;
  localparam int WAY_W = (S_BITS > 0) ? S_BITS : 1;
  localparam int AGE_W = WAY_W;
  localparam logic [CNT_W-1:0] BLK_BYTES = CNT_W'(1 << B_BITS);
  localparam logic [CNT_W-1:0] WT_BYTES  = CNT_W'(4);

  logic [SET_W-1:0] set_idx;
  logic [TAG_W-1:0] tag;
  logic             unused_off;

  if (IDX_W > 0) begin : g_idx
    assign set_idx = req_addr[B_BITS +: SET_W];
  end else begin : g_no_idx
    assign set_idx = '0;
  end
  assign tag        = req_addr[31 -: TAG_W];
  assign unused_off = ^req_addr[B_BITS-1:0];

  logic [WAYS-1:0]  hit_vec, valid_row, dirty_row;
  logic [AGE_W-1:0] age_row [WAYS];
  logic [WAY_W-1:0] victim, hit_way, upd_way;
  logic fire, hit, fill, upd_en, dirty_set, dirty_clr, evict_dirty;
  logic [CNT_W-1:0] bytes;

  assign req_ready = !rsp_valid;
  assign fire      = req_valid && req_ready;
  assign hit       = |hit_vec;

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (hit_vec[w]) hit_way = WAY_W'(w);
  end

  always_comb begin
    fill        = fire && !hit && (!req_write || wp_write_back);
    upd_en      = fire && (hit || fill);
    upd_way     = hit ? hit_way : victim;
    dirty_set   = req_write && wp_write_back;
    dirty_clr   = fill && !req_write;
    evict_dirty = fill && valid_row[victim] && dirty_row[victim];
    bytes       = (fill ? BLK_BYTES : '0)
                + (evict_dirty ? BLK_BYTES : '0)
                + ((req_write && !wp_write_back) ? WT_BYTES : '0);
  end

  cmc_victim_sel #(.WAYS(WAYS), .WAY_W(WAY_W), .AGE_W(AGE_W)) victim_i (
    .clk(clk), .rst_n(rst_n), .valid_row(valid_row), .age_row(age_row), .victim(victim)
  );

  cmc_tag_store #(
    .SETS(SETS), .WAYS(WAYS), .SET_W(SET_W), .TAG_W(TAG_W), .WAY_W(WAY_W), .AGE_W(AGE_W)
  ) tags_i (
    .clk(clk), .rst_n(rst_n), .rd_set(set_idx), .rd_tag(tag),
    .upd_en(upd_en), .upd_way(upd_way), .upd_fill(fill),
    .upd_dirty_set(dirty_set), .upd_dirty_clr(dirty_clr),
    .hit_vec(hit_vec), .valid_row(valid_row), .dirty_row(dirty_row), .age_row(age_row)
  );

  cmc_stats #(.CNT_W(CNT_W)) stats_i (
    .clk(clk), .rst_n(rst_n), .clear(stats_clear),
    .ev_fire(fire), .ev_write(req_write), .ev_hit(hit), .ev_wb(wp_write_back),
    .ev_bytes(bytes), .sel(stat_sel), .value(stat_value)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
    end else begin
      rsp_valid <= fire;
      if (fire) rsp_hit <= hit;
    end
  end

  // R3: every response pulse follows an accepted request
  a_r3_rsp_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && req_ready));

  // R3: the response lasts a single cycle
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

// File: tb/cache_meta_ctrl_tb_top.sv
module cache_meta_ctrl_tb_top;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wp_write_back = 1'b1;
  logic        stats_clear = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [3:0]  stat_sel = '0;
  logic        req_ready, rsp_valid, rsp_hit;
  logic        sat_ready, sat_rsp_valid, sat_rsp_hit;
  logic [31:0] stat_value;
  logic [7:0]  sat_value;

  int chk_cnt  = 0;
  int fail_cnt = 0;

  always #(CLK_NS/2) clk = ~clk;

  cache_meta_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .wp_write_back(wp_write_back), .stats_clear(stats_clear),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .stat_sel(stat_sel), .stat_value(stat_value)
  );

  cache_meta_ctrl #(.CNT_W(8)) dut_sat (
    .clk(clk), .rst_n(rst_n), .wp_write_back(wp_write_back), .stats_clear(stats_clear),
    .req_valid(req_valid), .req_ready(sat_ready), .req_write(req_write), .req_addr(req_addr),
    .rsp_valid(sat_rsp_valid), .rsp_hit(sat_rsp_hit), .stat_sel(stat_sel), .stat_value(sat_value)
  );

  // {write, write_back, address, expected_hit}; set 0 tags 0..3 at 0x000/0x200/0x400/0x600
  localparam int NVEC = 14;
  localparam logic [34:0] VEC [NVEC] = '{
    {1'b0, 1'b1, 32'h0000_0000, 1'b0},  // R2 cold miss, fills way 0
    {1'b0, 1'b1, 32'h0000_0004, 1'b1},  // R1 other offset, same block
    {1'b1, 1'b1, 32'h0000_0200, 1'b0},  // R6 write-back miss allocates dirty, R4 way 1 free
    {1'b0, 1'b1, 32'h0000_0000, 1'b1},  // R5 A becomes most recent
    {1'b0, 1'b1, 32'h0000_0400, 1'b0},  // R4 evicts dirty B (R8 +32)
    {1'b0, 1'b1, 32'h0000_0200, 1'b0},  // R5 evicts A, clean
    {1'b1, 1'b0, 32'h0000_0600, 1'b0},  // R7 write-through miss, no allocate
    {1'b0, 1'b0, 32'h0000_0600, 1'b0},  // R7 proves no allocate; evicts C
    {1'b1, 1'b0, 32'h0000_0200, 1'b1},  // R7 write-through hit
    {1'b1, 1'b1, 32'h0000_0600, 1'b1},  // R12 policy switch: write-back hit marks D dirty
    {1'b0, 1'b1, 32'h0000_0000, 1'b0},  // R6 evicts B, which stayed clean
    {1'b0, 1'b1, 32'h0000_0600, 1'b1},  // R5 D still resident
    {1'b0, 1'b1, 32'h0000_0010, 1'b0},  // R1 set 1 miss
    {1'b1, 1'b0, 32'h0000_0010, 1'b1}   // R7 write-through hit in set 1
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    chk_cnt++;
    if (act !== exp) begin
      fail_cnt++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic wb, input logic clr,
                        input logic [31:0] a, output logic hit, output logic hs_ok);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; wp_write_back = wb; req_addr = a; stats_clear = clr;
    @(negedge clk);
    req_valid = 1'b0; stats_clear = 1'b0;
    hs_ok = rsp_valid && !req_ready;
    hit   = rsp_hit;
    @(negedge clk);
    hs_ok = hs_ok && !rsp_valid;
  endtask

  task automatic stat(input logic [3:0] sel, output logic [31:0] v, output logic [7:0] vs);
    @(negedge clk);
    stat_sel = sel;
    #1;
    v  = stat_value;
    vs = sat_value;
  endtask

  task automatic clear_only();
    @(negedge clk); stats_clear = 1'b1;
    @(negedge clk); stats_clear = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", chk_cnt, fail_cnt);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 100000);
    fail_cnt++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic        h, ok;
    logic [31:0] v;
    logic [7:0]  vs;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 reset state
    check("R2 req_ready after reset", 32'(req_ready), 32'd1);
    check("R2 rsp_valid after reset", 32'(rsp_valid), 32'd0);
    for (int s = 0; s < 9; s++) begin
      stat(4'(s), v, vs);
      check("R2 counter zero after reset", v, 32'd0);
    end

    // vector walk
    for (int i = 0; i < NVEC; i++) begin
      access(VEC[i][34], VEC[i][33], 1'b0, VEC[i][32:1], h, ok);
      if (i == 0) check("R3 handshake pulse", 32'(ok), 32'd1);
      check($sformatf("R12 hit/miss step %0d", i), 32'(h), 32'(VEC[i][0]));
    end

    // R9 counter readout, expected from the walk above
    stat(4'd0, v, vs); check("R9 accesses", v, 32'd14);
    stat(4'd1, v, vs); check("R9 reads", v, 32'd9);
    stat(4'd2, v, vs); check("R9 read hits", v, 32'd3);
    stat(4'd3, v, vs); check("R9 read misses", v, 32'd6);
    stat(4'd4, v, vs); check("R9 writes", v, 32'd5);
    stat(4'd5, v, vs); check("R9 write hits", v, 32'd3);
    stat(4'd6, v, vs); check("R7 write misses exclude write-through", v, 32'd1);
    stat(4'd7, v, vs); check("R7 total misses", v, 32'd7);
    stat(4'd8, v, vs); check("R8 bytes transferred", v, 32'd140);
    stat(4'd12, v, vs); check("R9 unused select reads zero", v, 32'd0);

    // R11 clear collides with an accepted miss: counts dropped, metadata kept
    access(1'b0, 1'b1, 1'b1, 32'h0000_0800, h, ok);
    check("R11 colliding access misses", 32'(h), 32'd0);
    stat(4'd0, v, vs); check("R11 accesses cleared", v, 32'd0);
    stat(4'd8, v, vs); check("R11 bytes cleared", v, 32'd0);
    access(1'b0, 1'b1, 1'b0, 32'h0000_0800, h, ok);
    check("R11 block filled despite clear", 32'(h), 32'd1);
    stat(4'd0, v, vs); check("R11 accesses after repeat", v, 32'd1);
    stat(4'd2, v, vs); check("R11 read hits after repeat", v, 32'd1);
    clear_only();
    stat(4'd0, v, vs); check("R11 plain clear", v, 32'd0);

    // R10 saturation: 20 fresh-tag read misses in sets 1..20, 320 bytes
    for (int i = 0; i < 20; i++) begin
      access(1'b0, 1'b1, 1'b0, ((32'h100 + 32'(i)) << 9) | (32'(i + 1) << 4), h, ok);
      check("R4 fresh tag misses", 32'(h), 32'd0);
    end
    stat(4'd8, v, vs);
    check("R8 bytes of 20 fills", v, 32'd320);
    check("R10 narrow byte counter saturates", 32'(vs), 32'd255);
    stat(4'd0, v, vs);
    check("R10 narrow access count below limit", 32'(vs), 32'd20);

    finish_run();
  end
endmodule